// File: doc/BRIEF.md
# Scheduled Link Latency Aligner

This block brings a group of serial receive lanes onto one shared time base. A single align command starts two kinds of timing. A launch counter on the transmit side replaces one payload word on every lane with a comma word once the counter reaches a programmed launch count. On each receive lane, an arrival counter starts from the same command and stops when that lane's received word equals the comma.

Each lane compares its measured arrival count with a programmed scheduled arrival count. From the difference and a programmed baseline delay it sets the tap of a per-lane shift-register delay line. Every healthy lane then delivers its data with the same end-to-end latency, whatever its own link latency is. A lane whose comma comes late, never comes, or needs more delay than the line holds raises an error flag instead of an aligned flag.

Launch and arrival counts are in parallel-word cycles. When several words pass per bunch clock, the compensation therefore has a resolution finer than one bunch clock.

Top module: `sla_aligner`

## Requirements
- R1: After reset every `aligned` and `align_err` bit is 0, `tx_data` equals `tx_payload` on all lanes, and each lane's `rx_out` equals its `rx_data` in the same cycle, because the tap is 0.
- R2: If `align_cmd` is high in cycle a, every lane of `tx_data` carries the comma word `COMMA` (default 16'h00BC) in cycle a+1+`launch_at`, and in no other cycle for that command.
- R3: In every other cycle, each lane of `tx_data` equals its lane of `tx_payload`.
- R4: A lane's arrival count is the number of cycles from cycle a+1 to the cycle in which its `rx_data` equals `COMMA`. When that count A meets A ≤ `arrive_at` and `base_delay` + `arrive_at` − A ≤ DEPTH−1, the lane sets `aligned` and its tap becomes `base_delay` + `arrive_at` − A, starting the cycle after detection. The comma then leaves `rx_out` in cycle a+1+`arrive_at`+`base_delay` on every aligned lane.
- R5: If A > `arrive_at` (a late comma), the lane raises `align_err`, leaves `aligned` at 0 and keeps the tap at `base_delay`.
- R6: If no comma is seen while the arrival count runs from 0 to TIMEOUT−1, the lane raises `align_err` in cycle a+TIMEOUT+1 and keeps the tap at `base_delay`.
- R7: If the required tap exceeds DEPTH−1, the lane raises `align_err` and keeps the tap at `base_delay`.
- R8: `align_cmd` clears `aligned` and `align_err` and loads the tap with `base_delay` from the next cycle on. A set `aligned` or `align_err` holds until the next `align_cmd`.
- R9: `rx_out` of a lane equals that lane's `rx_data` from the number of cycles earlier given by its current tap. Before reset ends, the history reads as zero.
- R10: Lanes are independent: one lane's error leaves the other lanes' alignment and taps unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_cmd | input | 1 | Global align command, one-cycle pulse |
| launch_at | input | CW | Scheduled launch count |
| arrive_at | input | CW | Scheduled arrival count |
| base_delay | input | $clog2(DEPTH) | Fixed baseline receive delay |
| tx_payload | input | NCH*W | Transmit payload, lane i at bits [i*W +: W] |
| tx_data | output | NCH*W | Transmit words with the comma inserted |
| rx_data | input | NCH*W | Received parallel words |
| rx_out | output | NCH*W | Received words after the selected delay |
| aligned | output | NCH | Lane aligned successfully |
| align_err | output | NCH | Lane failed: late, timed out or out of range |

## Verification
The bench builds the block with NCH=4, W=16, DEPTH=16 and TIMEOUT=40. It models the links as per-lane fixed latencies between 0 and 40 words. With these values a single run can reach every compensation outcome: taps spread from 2 up to the line's last tap of 15, a lane one word past its schedule, a lane whose tap would overflow by two, and a lane whose comma comes after the 40-cycle window. The baseline is raised from 2 to 8 between runs, which moves the overflow edge within reach of an ordinary latency.

// File: rtl/sla_pkg.sv
package sla_pkg;

  // Tap needed so that data leaves with latency base + sched - launch.
  function automatic int tap_needed(int base, int sched, int arr);
    return base + sched - arr;
  endfunction

  // True when a measured arrival can be compensated within the line.
  function automatic bit tap_fits(int base, int sched, int arr, int depth);
    return (arr <= sched) && (tap_needed(base, sched, arr) <= depth - 1);
  endfunction

endpackage

// File: rtl/sla_launcher.sv
module sla_launcher #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          align_cmd,
  input  logic [CW-1:0] launch_at,
  output logic          send_comma
);
  logic          active;
  logic [CW-1:0] cnt;

  assign send_comma = active && (cnt == launch_at);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (align_cmd) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (send_comma) active <= 1'b0;
      else            cnt    <= cnt + 1'b1;
    end
  end

  AST_ONE_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    send_comma && !align_cmd |=> !send_comma); // R2

endmodule

// File: rtl/sla_arrival.sv
module sla_arrival
  import sla_pkg::*;
#(
  parameter int       W       = 16,
  parameter int       CW      = 8,
  parameter int       DEPTH   = 16,
  parameter int       TIMEOUT = 64,
  parameter logic [W-1:0] COMMA = 16'h00BC,
  localparam int      DW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          align_cmd,
  input  logic [CW-1:0] arrive_at,
  input  logic [DW-1:0] base_delay,
  input  logic [W-1:0]  rx_word,
  output logic [DW-1:0] tap,
  output logic          aligned,
  output logic          err
);
  logic          meas;
  logic [CW-1:0] cnt;
  logic          hit, timeout_ev, fits_ev;
  int            need;

  assign hit        = meas && (rx_word == COMMA);
  assign timeout_ev = meas && !hit && (int'(cnt) == TIMEOUT - 1);
  assign need       = tap_needed(int'(base_delay), int'(arrive_at), int'(cnt));
  assign fits_ev    = tap_fits(int'(base_delay), int'(arrive_at), int'(cnt), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas    <= 1'b0;
      cnt     <= '0;
      tap     <= '0;
      aligned <= 1'b0;
      err     <= 1'b0;
    end else if (align_cmd) begin
      meas    <= 1'b1;
      cnt     <= '0;
      tap     <= base_delay;
      aligned <= 1'b0;
      err     <= 1'b0;
    end else if (meas) begin
      if (hit) begin
        meas <= 1'b0;
        if (fits_ev) begin
          aligned <= 1'b1;
          tap     <= need[DW-1:0];
        end else begin
          err <= 1'b1;
        end
      end else if (timeout_ev) begin
        meas <= 1'b0;
        err  <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CLEAR_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    align_cmd |=> !aligned && !err); // R8
  AST_HOLD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    aligned && !align_cmd |=> aligned); // R8
  AST_HOLD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err && !align_cmd |=> err); // R8
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(aligned && err)); // R5
  AST_TAP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> tap == base_delay); // R7
  AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev && !align_cmd |=> err && !aligned); // R6

endmodule

// File: rtl/sla_delay_line.sv
module sla_delay_line #(
  parameter int  W     = 16,
  parameter int  DEPTH = 16,
  localparam int DW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  din,
  input  logic [DW-1:0] tap,
  output logic [W-1:0]  dout
);
  logic [W-1:0] sr [DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH - 1; i++) sr[i] <= '0;
    end else begin
      sr[0] <= din;
      for (int i = 1; i < DEPTH - 1; i++) sr[i] <= sr[i-1];
    end
  end

  always_comb begin
    dout = din;
    for (int i = 1; i < DEPTH; i++)
      if (int'(tap) == i) dout = sr[i-1];
  end

  AST_TAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == DW'(1)) && $stable(tap) |-> dout == $past(din)); // R9

endmodule

// File: rtl/sla_aligner.sv
module sla_aligner
  import sla_pkg::*;
#(
  parameter int           NCH     = 4,
  parameter int           W       = 16,
  parameter int           CW      = 8,
  parameter int           DEPTH   = 16,
  parameter int           TIMEOUT = 64,
  parameter logic [W-1:0] COMMA   = 16'h00BC,
  localparam int          DW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             align_cmd,
  input  logic [CW-1:0]    launch_at,
  input  logic [CW-1:0]    arrive_at,
  input  logic [DW-1:0]    base_delay,
  input  logic [NCH*W-1:0] tx_payload,
  output logic [NCH*W-1:0] tx_data,
  input  logic [NCH*W-1:0] rx_data,
  output logic [NCH*W-1:0] rx_out,
  output logic [NCH-1:0]   aligned,
  output logic [NCH-1:0]   align_err
);
  logic send_comma;

  sla_launcher #(.CW(CW)) u_launch (
    .clk(clk), .rst_n(rst_n), .align_cmd(align_cmd),
    .launch_at(launch_at), .send_comma(send_comma)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic [DW-1:0] tap;

    assign tx_data[c*W +: W] = send_comma ? COMMA : tx_payload[c*W +: W];

    sla_arrival #(.W(W), .CW(CW), .DEPTH(DEPTH), .TIMEOUT(TIMEOUT), .COMMA(COMMA)) u_arr (
      .clk(clk), .rst_n(rst_n), .align_cmd(align_cmd),
      .arrive_at(arrive_at), .base_delay(base_delay),
      .rx_word(rx_data[c*W +: W]), .tap(tap),
      .aligned(aligned[c]), .err(align_err[c])
    );

    sla_delay_line #(.W(W), .DEPTH(DEPTH)) u_dly (
      .clk(clk), .rst_n(rst_n), .din(rx_data[c*W +: W]),
      .tap(tap), .dout(rx_out[c*W +: W])
    );

    AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !send_comma |-> tx_data[c*W +: W] == tx_payload[c*W +: W]); // R3
  end

endmodule

// File: tb/tb_sla_aligner.sv
module tb_sla_aligner;
  localparam int NCH = 4, W = 16, CW = 8, DEPTH = 16, TMO = 40, DW = 4;
  localparam logic [W-1:0] COMMA = 16'h00BC;
  localparam int HMAX = 1024;

  logic clk = 1'b0, rst_n = 1'b0, align_cmd = 1'b0;
  logic [CW-1:0] launch_at = 8'd3, arrive_at = 8'd12;
  logic [DW-1:0] base_delay = 4'd2;
  logic [NCH*W-1:0] tx_payload = '0, tx_data, rx_data = '0, rx_out;
  logic [NCH-1:0] aligned, align_err;

  always #4 clk = ~clk;

  sla_aligner #(.NCH(NCH), .W(W), .CW(CW), .DEPTH(DEPTH), .TIMEOUT(TMO), .COMMA(COMMA)) dut (
    .clk(clk), .rst_n(rst_n), .align_cmd(align_cmd), .launch_at(launch_at),
    .arrive_at(arrive_at), .base_delay(base_delay), .tx_payload(tx_payload),
    .tx_data(tx_data), .rx_data(rx_data), .rx_out(rx_out),
    .aligned(aligned), .align_err(align_err)
  );

  int checks = 0, fails = 0;
  int n = 0;
  int cmd_n = -100;
  int lat [NCH];
  int ev_n [NCH], ev_tap [NCH];
  bit ev_al [NCH], ev_er [NCH];
  int cur_tap [NCH];
  bit cur_al [NCH], cur_er [NCH];
  logic [W-1:0] txh [NCH][HMAX];
  logic [W-1:0] rxh [NCH][HMAX];
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input int ch, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s lane %0d cycle %0d: actual %h expected %h", req, ch, n, act, exp);
    end
  endtask

  // Predict each lane's outcome from the schedule and its link latency.
  task automatic plan_cmd(input int a);
    cmd_n = a;
    for (int c = 0; c < NCH; c++) begin
      int arr, need;
      arr = int'(launch_at) + lat[c];
      ev_al[c] = 0; ev_er[c] = 0; ev_tap[c] = int'(base_delay);
      if (arr > TMO - 1) begin
        ev_n[c] = a + TMO + 1; ev_er[c] = 1;
      end else begin
        ev_n[c] = a + arr + 2;
        need = int'(base_delay) + int'(arrive_at) - arr;
        if (arr > int'(arrive_at) || need > DEPTH - 1) ev_er[c] = 1;
        else begin ev_al[c] = 1; ev_tap[c] = need; end
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    align_cmd = (n == cmd_n);
    for (int c = 0; c < NCH; c++) begin
      logic [W-1:0] pay, etx, erx;
      int src;
      if (n == cmd_n + 1) begin cur_al[c] = 0; cur_er[c] = 0; cur_tap[c] = int'(base_delay); end
      if (n == ev_n[c]) begin cur_al[c] = ev_al[c]; cur_er[c] = ev_er[c]; cur_tap[c] = ev_tap[c]; end
      pay = {4'hA, 12'(n)};
      etx = (n == cmd_n + 1 + int'(launch_at)) ? COMMA : pay;
      txh[c][n] = etx;
      rxh[c][n] = (n - lat[c] >= 0) ? txh[c][n - lat[c]] : '0;
      tx_payload[c*W +: W] = pay;
      rx_data[c*W +: W] = rxh[c][n];
    end
    #1;
    for (int c = 0; c < NCH; c++) begin
      logic [W-1:0] erx;
      erx = (n - cur_tap[c] >= 0) ? rxh[c][n - cur_tap[c]] : '0;
      chk(tx_data[c*W +: W] === txh[c][n], "R2/R3", c, tx_data[c*W +: W], txh[c][n]);
      chk(rx_out[c*W +: W] === erx, "R9", c, rx_out[c*W +: W], erx);
      chk(aligned[c] === cur_al[c], "R8", c, W'(aligned[c]), W'(cur_al[c]));
      chk(align_err[c] === cur_er[c], tag, c, W'(align_err[c]), W'(cur_er[c]));
      if (n == cmd_n + 1 + int'(arrive_at) + int'(base_delay) && cur_al[c])
        chk(rx_out[c*W +: W] === COMMA, "R4", c, rx_out[c*W +: W], COMMA);
    end
    n++;
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      lat[c] = 0; ev_n[c] = -1; cur_tap[c] = 0; cur_al[c] = 0; cur_er[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state observed in the first cycles
    tag = "R1";
    n = 0;
    run(8);
    // R4: all lanes reachable, taps 9, 6, 2, 11
    tag = "R4";
    lat = '{2, 5, 9, 0};
    plan_cmd(n + 2);
    run(45);
    // R5 and R10: lane 0 one word late, other lanes align
    tag = "R5";
    lat = '{10, 4, 1, 7};
    plan_cmd(n + 2);
    run(45);
    chk(aligned === 4'b1110, "R10", 0, W'(aligned), 16'h000E);
    chk(align_err === 4'b0001, "R10", 0, W'(align_err), 16'h0001);
    // R7: larger baseline pushes lane 0 past the last tap
    tag = "R7";
    base_delay = 4'd8;
    lat = '{0, 6, 3, 9};
    plan_cmd(n + 2);
    run(45);
    // R6: lane 0 comma beyond the timeout window
    tag = "R6";
    lat = '{40, 2, 2, 2};
    plan_cmd(n + 2);
    run(70);
    // R8: status held while idle, cleared and rebuilt by a new command
    tag = "R8";
    base_delay = 4'd2;
    lat = '{2, 5, 9, 0};
    run(10);
    plan_cmd(n + 2);
    run(45);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule